// File: doc/BRIEF.md
# PIPE Link Bring-Up Sequencer

This block walks a four-lane PIPE physical layer through its start-up in a fixed order. It leaves reset and waits in a Gen 1 idle state until the PHY status flags clear. It then opens the link at Gen 1 and waits for every receiver to report symbol lock inside a fixed counter window. Next it sends Gen 1 pattern data for a fixed interval, and then asks for the Gen 2 rate. Once all four lanes acknowledge the rate change, it opens the link again at Gen 2, and after the receivers lock a second time it settles in Gen 2 data transfer. In that final state it raises a flag telling a management agent that the link is ready.

The sequencer reads two per-lane flag buses: PHY status and receive sync status. Each is registered once before use. An internal phase counter clears on every state change and stops at its maximum value instead of wrapping. From the current state the block drives the rate select, the power-down code, electrical idle, a select that switches the transmit path to pattern data, and the management-ready flag. All of these outputs come straight from registers.

Top module: `pipe_bringup_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in its reset state within one clock edge, from any state. While in reset, the outputs are `rate_gen2`=0, `pd_state`=2'b10 (P1), `tx_elec_idle`=1, `tx_pattern_sel`=0 and `mgmt_ready`=0. The first edge with `rst` low moves the sequencer to the Gen 1 init state, which drives the same outputs.
- R2: The Gen 1 init state holds while the registered PHY status is nonzero. It moves to the Gen 1 link-open state on the first edge at which the registered PHY status is all zeros.
- R3: In a link-open state the outputs are: `rate_gen2` equal to that state's generation (0 for Gen 1, 1 for Gen 2), `pd_state`=2'b00 (P0), `tx_elec_idle`=0, `tx_pattern_sel`=0 and `mgmt_ready`=0.
- R4: A link-open state moves to its data state only on an edge at which the phase counter is at least 0x051 and the registered sync status is all ones (0xFF). If sync is already held, the earliest exit comes 0x52 edges after the state is entered.
- R5: The upper end of the window is inclusive. Sync reaching all ones exactly when the counter reads 0x164 still moves the sequencer to the data state.
- R6: The phase counter clears to zero on every state change and stops at its all-ones value. A link-open state whose window closes without sync stays in that state until reset, even if sync later arrives.
- R7: In the Gen 1 data state the outputs are `rate_gen2`=0, P0, `tx_elec_idle`=0, `tx_pattern_sel`=1 and `mgmt_ready`=0. The state moves to the rate-switch state on the edge at which the counter reads exactly 0x164, which is 0x165 edges after entry.
- R8: In the rate-switch state the outputs are `rate_gen2`=1, P1, `tx_elec_idle`=1 and `tx_pattern_sel`=0. The state holds until the registered PHY status is 4'b1111, so a partial acknowledgement does not move it. It then moves to the Gen 2 link-open state.
- R9: The Gen 2 data state is terminal, and only `rst` leaves it. Its outputs are `rate_gen2`=1, P0, `tx_elec_idle`=0, `tx_pattern_sel`=1 and `mgmt_ready`=1, whatever the flag inputs do.
- R10: The flag inputs pass through exactly one register stage. A flag change has no effect on the outputs after one edge; the earliest output change is two edges after the change.
- R11: `tx_pattern_sel` is high only in the two data states, and `mgmt_ready` is high only in the Gen 2 data state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_status_i | input | LANES (4) | Per-lane PHY status flags |
| rx_sync_i | input | SYNC_W (8) | Receive sync-status flags; all ones means every receiver is locked |
| rate_gen2 | output | 1 | 0 selects Gen 1, 1 selects Gen 2 |
| pd_state | output | 2 | Power-down code: 2'b00 is P0, 2'b10 is P1 |
| tx_elec_idle | output | 1 | Transmit electrical idle request |
| tx_pattern_sel | output | 1 | Sends pattern data on the transmit path |
| mgmt_ready | output | 1 | Link is up at Gen 2 and ready for management |

## Verification
Some properties are checked by the assertions on every cycle. The init and rate-switch states do not exit without their full handshake. A link-open state does not exit outside the counter window or without complete sync. The counter clears on a state change and stays pinned once saturated. The Gen 2 data state never exits, and the pattern select and ready flag never appear outside their states. Other behaviour only the bench scenarios can show. These are the exact cycle at which each window edge opens a transition, the one-register delay on the flag inputs, the fixed length of Gen 1 data, and a link that stays stuck after the counter has saturated past the window.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic [2:0] {
    S_RESET    = 3'd0,
    S_INIT_G1  = 3'd1,
    S_OPEN_G1  = 3'd2,
    S_DATA_G1  = 3'd3,
    S_RSWITCH  = 3'd4,
    S_OPEN_G2  = 3'd5,
    S_DATA_G2  = 3'd6
  } seq_state_t;

  localparam logic [1:0] PD_P0 = 2'b00;
  localparam logic [1:0] PD_P1 = 2'b10;

  typedef struct packed {
    logic       gen2;
    logic [1:0] pd;
    logic       eidle;
    logic       pat;
    logic       rdy;
  } ctl_t;

  function automatic ctl_t decode_ctl(seq_state_t s);
    ctl_t c;
    c = '{gen2: 1'b0, pd: PD_P1, eidle: 1'b1, pat: 1'b0, rdy: 1'b0};
    case (s)
      S_OPEN_G1: c = '{gen2: 1'b0, pd: PD_P0, eidle: 1'b0, pat: 1'b0, rdy: 1'b0};
      S_DATA_G1: c = '{gen2: 1'b0, pd: PD_P0, eidle: 1'b0, pat: 1'b1, rdy: 1'b0};
      S_RSWITCH: c = '{gen2: 1'b1, pd: PD_P1, eidle: 1'b1, pat: 1'b0, rdy: 1'b0};
      S_OPEN_G2: c = '{gen2: 1'b1, pd: PD_P0, eidle: 1'b0, pat: 1'b0, rdy: 1'b0};
      S_DATA_G2: c = '{gen2: 1'b1, pd: PD_P0, eidle: 1'b0, pat: 1'b1, rdy: 1'b1};
      default:   c = '{gen2: 1'b0, pd: PD_P1, eidle: 1'b1, pat: 1'b0, rdy: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pbs_in_reg.sv
module pbs_in_reg #(
  parameter int LANES  = 4,
  parameter int SYNC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  phy_status_i,
  input  logic [SYNC_W-1:0] rx_sync_i,
  output logic [LANES-1:0]  phy_q,
  output logic [SYNC_W-1:0] sync_q
);

  for (genvar g = 0; g < LANES; g++) begin : g_phy
    always_ff @(posedge clk) begin
      if (rst) phy_q[g] <= 1'b0;
      else     phy_q[g] <= phy_status_i[g];
    end
  end

  for (genvar g = 0; g < SYNC_W; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[g] <= 1'b0;
      else     sync_q[g] <= rx_sync_i[g];
    end
  end

endmodule

// File: rtl/pbs_phase_cnt.sv
module pbs_phase_cnt #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)         cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0)); // R6

  AST_CNT_PINNED: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX)); // R6

endmodule

// File: rtl/pbs_fsm.sv
module pbs_fsm
  import pbs_pkg::*;
#(
  parameter int              LANES  = 4,
  parameter int              SYNC_W = 8,
  parameter int              CNT_W  = 9,
  parameter logic [CNT_W-1:0] WIN_LO = 9'h051,
  parameter logic [CNT_W-1:0] WIN_HI = 9'h164
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  phy_q,
  input  logic [SYNC_W-1:0] sync_q,
  input  logic [CNT_W-1:0]  cnt,
  output seq_state_t        state,
  output seq_state_t        state_nx,
  output logic              chg
);

  localparam logic [LANES-1:0]  PHY_ALL  = '1;
  localparam logic [SYNC_W-1:0] SYNC_ALL = '1;

  logic in_win, locked, phy_idle, phy_ack;

  assign in_win   = (cnt >= WIN_LO) && (cnt <= WIN_HI);
  assign locked   = (sync_q == SYNC_ALL);
  assign phy_idle = (phy_q == '0);
  assign phy_ack  = (phy_q == PHY_ALL);

  always_comb begin
    state_nx = state;
    if (rst) begin
      state_nx = S_RESET;
    end else begin
      case (state)
        S_RESET:   state_nx = S_INIT_G1;
        S_INIT_G1: if (phy_idle)         state_nx = S_OPEN_G1;
        S_OPEN_G1: if (in_win && locked) state_nx = S_DATA_G1;
        S_DATA_G1: if (cnt == WIN_HI)    state_nx = S_RSWITCH;
        S_RSWITCH: if (phy_ack)          state_nx = S_OPEN_G2;
        S_OPEN_G2: if (in_win && locked) state_nx = S_DATA_G2;
        S_DATA_G2: state_nx = S_DATA_G2;
        default:   state_nx = S_RESET;
      endcase
    end
  end

  assign chg = (state_nx != state);

  always_ff @(posedge clk) begin
    state <= state_nx;
  end

  AST_INIT_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state == S_INIT_G1 && phy_q != '0) |=> (state == S_INIT_G1)); // R2

  AST_OPEN_GATED: assert property (@(posedge clk) disable iff (rst)
    ((state == S_OPEN_G1 || state == S_OPEN_G2) &&
     (cnt < WIN_LO || cnt > WIN_HI || sync_q != SYNC_ALL))
    |=> (state == $past(state))); // R4

  AST_RSWITCH_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state == S_RSWITCH && phy_q != PHY_ALL) |=> (state == S_RSWITCH)); // R8

  AST_DATA_G2_TERMINAL: assert property (@(posedge clk) disable iff (rst)
    (state == S_DATA_G2) |=> (state == S_DATA_G2)); // R9

endmodule

// File: rtl/pbs_out_reg.sv
module pbs_out_reg
  import pbs_pkg::*;
(
  input  logic       clk,
  input  seq_state_t state_nx,
  output ctl_t       ctl
);

  always_ff @(posedge clk) begin
    ctl <= decode_ctl(state_nx);
  end

endmodule

// File: rtl/pipe_bringup_seq.sv
module pipe_bringup_seq
  import pbs_pkg::*;
#(
  parameter int               LANES  = 4,
  parameter int               SYNC_W = 8,
  parameter int               CNT_W  = 9,
  parameter logic [CNT_W-1:0] WIN_LO = 9'h051,
  parameter logic [CNT_W-1:0] WIN_HI = 9'h164
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  phy_status_i,
  input  logic [SYNC_W-1:0] rx_sync_i,
  output logic              rate_gen2,
  output logic [1:0]        pd_state,
  output logic              tx_elec_idle,
  output logic              tx_pattern_sel,
  output logic              mgmt_ready
);

  logic [LANES-1:0]  phy_q;
  logic [SYNC_W-1:0] sync_q;
  logic [CNT_W-1:0]  cnt;
  logic              chg;
  seq_state_t        state, state_nx;
  ctl_t              ctl;

  pbs_in_reg #(.LANES(LANES), .SYNC_W(SYNC_W)) u_in (
    .clk(clk), .rst(rst),
    .phy_status_i(phy_status_i), .rx_sync_i(rx_sync_i),
    .phy_q(phy_q), .sync_q(sync_q)
  );

  pbs_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(chg), .cnt(cnt)
  );

  pbs_fsm #(
    .LANES(LANES), .SYNC_W(SYNC_W), .CNT_W(CNT_W),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_fsm (
    .clk(clk), .rst(rst), .phy_q(phy_q), .sync_q(sync_q), .cnt(cnt),
    .state(state), .state_nx(state_nx), .chg(chg)
  );

  pbs_out_reg u_out (
    .clk(clk), .state_nx(state_nx), .ctl(ctl)
  );

  assign rate_gen2      = ctl.gen2;
  assign pd_state       = ctl.pd;
  assign tx_elec_idle   = ctl.eidle;
  assign tx_pattern_sel = ctl.pat;
  assign mgmt_ready     = ctl.rdy;

  AST_PATTERN_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    tx_pattern_sel |-> (state == S_DATA_G1 || state == S_DATA_G2)); // R11

  AST_READY_IN_G2: assert property (@(posedge clk) disable iff (rst)
    mgmt_ready |-> (state == S_DATA_G2 && rate_gen2 && pd_state == PD_P0
                    && !tx_elec_idle)); // R9

  AST_RESET_OUTPUTS: assert property (@(posedge clk)
    rst |=> (!rate_gen2 && pd_state == PD_P1 && tx_elec_idle
             && !tx_pattern_sel && !mgmt_ready)); // R1

endmodule

// File: tb/test_pipe_bringup_seq.sv
module test_pipe_bringup_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] phy = 4'hF;
  logic [7:0] sync = 8'h00;
  logic       rate_gen2, tx_elec_idle, tx_pattern_sel, mgmt_ready;
  logic [1:0] pd_state;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  pipe_bringup_seq i_pipe_bringup_seq (
    .clk(clk), .rst(rst), .phy_status_i(phy), .rx_sync_i(sync),
    .rate_gen2(rate_gen2), .pd_state(pd_state), .tx_elec_idle(tx_elec_idle),
    .tx_pattern_sel(tx_pattern_sel), .mgmt_ready(mgmt_ready)
  );

  // expected output word: {gen2, pd[1:0], eidle, pat, rdy}
  localparam logic [5:0] O_IDLE  = 6'b0_10_1_0_0;
  localparam logic [5:0] O_OPEN1 = 6'b0_00_0_0_0;
  localparam logic [5:0] O_DATA1 = 6'b0_00_0_1_0;
  localparam logic [5:0] O_RSW   = 6'b1_10_1_0_0;
  localparam logic [5:0] O_OPEN2 = 6'b1_00_0_0_0;
  localparam logic [5:0] O_DATA2 = 6'b1_00_0_1_1;

  // vector: {phy[4], sync[8], cycles[12], expected[6], req[4]}
  localparam int NV = 15;
  localparam logic [33:0] VEC [NV] = '{
    {4'hF, 8'h00, 12'd5,   O_IDLE,  4'd2},  // R2 init holds, status busy
    {4'h0, 8'h00, 12'd1,   O_IDLE,  4'd10}, // R10 one edge: no effect yet
    {4'h0, 8'h00, 12'd2,   O_OPEN1, 4'd3},  // R3 Gen 1 link open
    {4'h0, 8'hFF, 12'd80,  O_OPEN1, 4'd4},  // R4 counter at 0x051, not yet out
    {4'h0, 8'hFF, 12'd1,   O_DATA1, 4'd4},  // R4 exits at window start
    {4'h0, 8'hFF, 12'd356, O_DATA1, 4'd7},  // R7 counter at 0x164
    {4'h0, 8'hFF, 12'd1,   O_RSW,   4'd7},  // R7 rate switch after 0x165
    {4'h7, 8'hFF, 12'd4,   O_RSW,   4'd8},  // R8 partial ack ignored
    {4'hF, 8'hFF, 12'd1,   O_RSW,   4'd10}, // R10 ack not yet registered-in
    {4'hF, 8'hFF, 12'd1,   O_OPEN2, 4'd8},  // R8 full ack -> Gen 2 open
    {4'h0, 8'h7F, 12'd355, O_OPEN2, 4'd5},  // R5 one lane unsynced
    {4'h0, 8'hFF, 12'd1,   O_OPEN2, 4'd5},  // R5 counter reaches 0x164
    {4'h0, 8'hFF, 12'd1,   O_DATA2, 4'd5},  // R5 inclusive upper edge
    {4'hF, 8'h00, 12'd20,  O_DATA2, 4'd9},  // R9 terminal
    {4'h5, 8'hAA, 12'd7,   O_DATA2, 4'd9}   // R9 terminal
  };

  task automatic check(input int req, input logic [5:0] exp);
    logic [5:0] act;
    act = {rate_gen2, pd_state, tx_elec_idle, tx_pattern_sel, mgmt_ready};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d: outputs act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, O_IDLE); // R1 reset outputs
    rst = 1'b0;
    repeat (1) @(negedge clk);
    check(1, O_IDLE); // R1 init state after release

    for (int i = 0; i < NV; i++) begin
      phy  = VEC[i][33:30];
      sync = VEC[i][29:22];
      repeat (int'(VEC[i][21:10])) @(negedge clk);
      check(int'(VEC[i][3:0]), VEC[i][9:4]);
    end

    // R1 reset from the terminal state
    rst = 1'b1;
    phy = 4'h0;
    sync = 8'h00;
    @(negedge clk);
    check(1, O_IDLE);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1, O_IDLE);
    @(negedge clk);
    check(2, O_OPEN1); // R2 status already clear

    // R6 window closes unsynced, counter saturates, sync arrives late
    repeat (600) @(negedge clk);
    check(6, O_OPEN1);
    sync = 8'hFF;
    repeat (100) @(negedge clk);
    check(6, O_OPEN1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule